// File: doc/BRIEF.md
# Compressed-Block Address Translation Unit

This unit turns a request for one 8x8 block of reference data into an external-memory command. Each block is stored in two layers. The truncation layer has a fixed size of 8·n bytes, where n is the number of truncated low bits per pixel. The unit finds it by arithmetic on the block index. The prediction layer has a variable size and is byte aligned. It is found through a per-block table entry that holds a byte offset and a length. The unit keeps a small direct-mapped copy of these entries on chip. When an entry is missing, the unit reads it from a table region in external memory. The data command waits until the entry arrives.

For writes to the prediction layer, the unit places the block at a running write pointer. There is one pointer per frame and plane. The length is rounded up to whole 8-byte units and the pointer advances by that rounded size. After the data write command, the unit writes the new entry both into the on-chip copy and out to the table region. Each frame and plane has its own three base addresses, one for each region. The number of blocks per row and the truncation depth are configuration inputs.

Top module: `blk_addr_xlat`

## Requirements
- R1: After reset the unit accepts requests (`req_ready_o` high) and drives no command on either the data port or the table port.
- R2: The block index is y·blocks_per_row + x, and the frame/plane slot is frame·2 + chroma. A truncation-layer request produces one command at the truncation base of that slot plus index·8·n, with a length of 8·n bytes. The command is a write when `req_write_i` is 1 and a read otherwise.
- R3: A truncation-layer request with n = 0 completes with no command, and the unit returns to accepting requests.
- R4: A table entry is 24 bits. Bits [23:6] hold the byte offset inside the slot's prediction region, and bits [5:0] hold the length in 8-byte units minus one. The entry of a block sits at the table base of its slot plus index·3.
- R5: A prediction-layer read produces a read command at the prediction base of the slot plus the entry offset, with a length of (length field + 1)·8 bytes.
- R6: When the entry is not held on chip, the unit issues exactly one table read before the data command. The data command is not raised while that read is outstanding, and the data and table ports are never active in the same cycle.
- R7: The on-chip copy has LINES entries and is direct-mapped on the low index bits. An entry matches only on the same slot and the full index. A matching request issues no table read. A request for another block on the same line replaces the entry.
- R8: A prediction-layer write of b bytes (1 to 512) is placed at the slot's write pointer, which starts at 0 after reset. The command length is ceil(b/8)·8. The pointer then advances by that amount, modulo 2^18.
- R9: After the data write command, the unit issues a table write of the new entry to the block's table address, and it keeps the entry on chip so that a following read of that block issues no table read.
- R10: Only one request is in service at a time (`req_ready_o` is low while busy). While a port's valid is high and its ready is low, all of that port's command fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_blk_per_row_i | input | XW | Blocks per row |
| cfg_trunc_i | input | NW | Truncated bits per pixel n |
| cfg_tr_base_i | input | 2·FRAMES·AW | Truncation-region base per slot, slot s at bits [s·AW +: AW] |
| cfg_pr_base_i | input | 2·FRAMES·AW | Prediction-region base per slot |
| cfg_tbl_base_i | input | 2·FRAMES·AW | Table-region base per slot |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_write_i | input | 1 | 1 = store block, 0 = fetch block |
| req_layer_i | input | 1 | 0 = truncation layer, 1 = prediction layer |
| req_frame_i | input | log2(FRAMES) | Frame number |
| req_chroma_i | input | 1 | Plane select, 1 = chroma |
| req_x_i | input | XW | Block column |
| req_y_i | input | YW | Block row |
| req_bytes_i | input | BW | Byte size of a prediction-layer write |
| cmd_valid_o | output | 1 | Data command valid |
| cmd_ready_i | input | 1 | Data command taken |
| cmd_write_o | output | 1 | Data command direction |
| cmd_addr_o | output | AW | Data byte address |
| cmd_len_o | output | BW | Data length in bytes |
| tbl_valid_o | output | 1 | Table access valid |
| tbl_ready_i | input | 1 | Table access taken |
| tbl_we_o | output | 1 | Table access is a write |
| tbl_addr_o | output | AW | Table entry byte address |
| tbl_wdata_o | output | 24 | Entry written |
| tbl_rvalid_i | input | 1 | Table read data valid |
| tbl_rdata_i | input | 24 | Entry read |

## Verification
The assertions check the port protocol on every cycle. Command fields must hold steady under back-pressure, the data and table ports must be mutually exclusive, no data command may appear while a table read is outstanding, every data length must be a nonzero multiple of eight, and the unit must be quiet whenever it reports ready. Whether an address or length is actually right, whether the on-chip copy hits or misses, including line aliasing, and how the write pointer allocates and rounds can only be shown by the bench. It does this by computing addresses from its own model of the pointers, the entries and the table contents, and by counting table reads around directed sequences.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ENTRY_W = 24;
  localparam int OFF_W   = 18;
  localparam int LENF_W  = 6;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [LENF_W-1:0] len_m1;
  } tbl_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_TBL_RD,
    ST_TBL_WT,
    ST_CMD,
    ST_TBL_WR
  } xlat_state_e;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int AW  = 32,
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int NFP = 8,
  parameter int NW  = 3,
  parameter int BW  = 10,
  parameter int FPW = $clog2(NFP),
  parameter int IW  = XW + YW
) (
  input  logic [XW-1:0]     bpr_i,
  input  logic [NW-1:0]     trunc_i,
  input  logic [NFP*AW-1:0] tr_base_i,
  input  logic [NFP*AW-1:0] pr_base_i,
  input  logic [NFP*AW-1:0] tbl_base_i,
  input  logic [FPW-1:0]    fp_i,
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  input  logic [xlat_pkg::OFF_W-1:0] off_i,
  output logic [IW-1:0]     idx_o,
  output logic [AW-1:0]     tr_addr_o,
  output logic [AW-1:0]     tbl_addr_o,
  output logic [AW-1:0]     pr_addr_o,
  output logic [BW-1:0]     tr_len_o
);
  logic [AW-1:0] tr_b  [NFP];
  logic [AW-1:0] pr_b  [NFP];
  logic [AW-1:0] tbl_b [NFP];

  for (genvar g = 0; g < NFP; g++) begin : g_slot
    assign tr_b[g]  = tr_base_i[g*AW +: AW];
    assign pr_b[g]  = pr_base_i[g*AW +: AW];
    assign tbl_b[g] = tbl_base_i[g*AW +: AW];
  end

  logic [AW-1:0] idx_w;
  logic [AW-1:0] tr_step;

  assign idx_o     = IW'(y_i) * IW'(bpr_i) + IW'(x_i);
  assign idx_w     = AW'(idx_o);
  assign tr_step   = AW'({trunc_i, 3'b000});
  assign tr_len_o  = BW'({trunc_i, 3'b000});
  assign tr_addr_o = tr_b[fp_i] + idx_w * tr_step;
  // 3-byte entries: idx*3 as shift plus add
  assign tbl_addr_o = tbl_b[fp_i] + (idx_w << 1) + idx_w;
  assign pr_addr_o  = pr_b[fp_i] + AW'(off_i);
endmodule

// File: rtl/xlat_entry_cache.sv
module xlat_entry_cache #(
  parameter int LINES = 16,
  parameter int KW    = 19,
  parameter int LW    = $clog2(LINES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [KW-1:0]         key_i,
  output logic                  hit_o,
  output xlat_pkg::tbl_entry_t  entry_o,
  input  logic                  we_i,
  input  xlat_pkg::tbl_entry_t  entry_i
);
  logic [LINES-1:0]     vld_q;
  logic [KW-1:0]        tag_q  [LINES];
  xlat_pkg::tbl_entry_t data_q [LINES];
  logic [LW-1:0]        line;

  assign line    = key_i[LW-1:0];
  assign hit_o   = vld_q[line] && (tag_q[line] == key_i);
  assign entry_o = data_q[line];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[line] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[line]  <= key_i;
      data_q[line] <= entry_i;
    end
  end
endmodule

// File: rtl/xlat_wr_alloc.sv
module xlat_wr_alloc #(
  parameter int NFP = 8,
  parameter int BW  = 10,
  parameter int FPW = $clog2(NFP)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [FPW-1:0]       fp_i,
  input  logic [BW-1:0]        bytes_i,
  input  logic                 alloc_i,
  output xlat_pkg::tbl_entry_t entry_o
);
  localparam int OW = xlat_pkg::OFF_W;

  logic [OW-1:0] ptr_q [NFP];
  logic [BW:0]   sum;
  logic [6:0]    units;

  assign sum   = {1'b0, bytes_i} + (BW+1)'(7);
  assign units = 7'(sum >> 3);
  assign entry_o.off    = ptr_q[fp_i];
  assign entry_o.len_m1 = 6'(units - 7'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFP; i++) ptr_q[i] <= '0;
    end else if (alloc_i) begin
      ptr_q[fp_i] <= ptr_q[fp_i] + OW'({units, 3'b000});
    end
  end
endmodule

// File: rtl/blk_addr_xlat.sv
module blk_addr_xlat #(
  parameter int AW     = 32,
  parameter int XW     = 8,
  parameter int YW     = 8,
  parameter int FRAMES = 4,
  parameter int LINES  = 16,
  parameter int NW     = 3,
  parameter int BW     = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [XW-1:0]               cfg_blk_per_row_i,
  input  logic [NW-1:0]               cfg_trunc_i,
  input  logic [2*FRAMES*AW-1:0]      cfg_tr_base_i,
  input  logic [2*FRAMES*AW-1:0]      cfg_pr_base_i,
  input  logic [2*FRAMES*AW-1:0]      cfg_tbl_base_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic                        req_layer_i,
  input  logic [$clog2(FRAMES)-1:0]   req_frame_i,
  input  logic                        req_chroma_i,
  input  logic [XW-1:0]               req_x_i,
  input  logic [YW-1:0]               req_y_i,
  input  logic [BW-1:0]               req_bytes_i,
  output logic                        cmd_valid_o,
  input  logic                        cmd_ready_i,
  output logic                        cmd_write_o,
  output logic [AW-1:0]               cmd_addr_o,
  output logic [BW-1:0]               cmd_len_o,
  output logic                        tbl_valid_o,
  input  logic                        tbl_ready_i,
  output logic                        tbl_we_o,
  output logic [AW-1:0]               tbl_addr_o,
  output logic [23:0]                 tbl_wdata_o,
  input  logic                        tbl_rvalid_i,
  input  logic [23:0]                 tbl_rdata_i
);
  import xlat_pkg::*;

  localparam int FRW = $clog2(FRAMES);
  localparam int NFP = 2 * FRAMES;
  localparam int FPW = FRW + 1;
  localparam int IW  = XW + YW;
  localparam int KW  = FPW + IW;

  xlat_state_e state_q;
  logic            wr_q, layer_q;
  logic [FPW-1:0]  fp_q;
  logic [XW-1:0]   x_q;
  logic [YW-1:0]   y_q;
  logic [BW-1:0]   bytes_q;
  tbl_entry_t      ent_q;

  logic [IW-1:0]   idx;
  logic [AW-1:0]   tr_addr, tbl_addr, pr_addr;
  logic [BW-1:0]   tr_len;
  logic            hit;
  tbl_entry_t      hit_entry, alloc_entry, fill_entry;
  logic            alloc_fire, cache_we;
  logic            is_pr_wr;

  xlat_addr_gen #(
    .AW(AW), .XW(XW), .YW(YW), .NFP(NFP), .NW(NW), .BW(BW), .FPW(FPW), .IW(IW)
  ) u_addr (
    .bpr_i      (cfg_blk_per_row_i),
    .trunc_i    (cfg_trunc_i),
    .tr_base_i  (cfg_tr_base_i),
    .pr_base_i  (cfg_pr_base_i),
    .tbl_base_i (cfg_tbl_base_i),
    .fp_i       (fp_q),
    .x_i        (x_q),
    .y_i        (y_q),
    .off_i      (ent_q.off),
    .idx_o      (idx),
    .tr_addr_o  (tr_addr),
    .tbl_addr_o (tbl_addr),
    .pr_addr_o  (pr_addr),
    .tr_len_o   (tr_len)
  );

  assign is_pr_wr   = wr_q && layer_q;
  assign alloc_fire = (state_q == ST_DECIDE) && is_pr_wr;
  assign cache_we   = alloc_fire || ((state_q == ST_TBL_WT) && tbl_rvalid_i);
  assign fill_entry = (state_q == ST_TBL_WT) ? tbl_entry_t'(tbl_rdata_i) : alloc_entry;

  xlat_entry_cache #(.LINES(LINES), .KW(KW)) u_cache (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_i   ({fp_q, idx}),
    .hit_o   (hit),
    .entry_o (hit_entry),
    .we_i    (cache_we),
    .entry_i (fill_entry)
  );

  xlat_wr_alloc #(.NFP(NFP), .BW(BW), .FPW(FPW)) u_alloc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fp_i    (fp_q),
    .bytes_i (bytes_q),
    .alloc_i (alloc_fire),
    .entry_o (alloc_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      layer_q <= 1'b0;
      fp_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      bytes_q <= '0;
      ent_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          layer_q <= req_layer_i;
          fp_q    <= {req_frame_i, req_chroma_i};
          x_q     <= req_x_i;
          y_q     <= req_y_i;
          bytes_q <= req_bytes_i;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (!layer_q) begin
            state_q <= (cfg_trunc_i == '0) ? ST_IDLE : ST_CMD;
          end else if (wr_q) begin
            ent_q   <= alloc_entry;
            state_q <= ST_CMD;
          end else if (hit) begin
            ent_q   <= hit_entry;
            state_q <= ST_CMD;
          end else begin
            state_q <= ST_TBL_RD;
          end
        end
        ST_TBL_RD: if (tbl_ready_i) state_q <= ST_TBL_WT;
        ST_TBL_WT: if (tbl_rvalid_i) begin
          ent_q   <= tbl_entry_t'(tbl_rdata_i);
          state_q <= ST_CMD;
        end
        ST_CMD: if (cmd_ready_i) state_q <= is_pr_wr ? ST_TBL_WR : ST_IDLE;
        ST_TBL_WR: if (tbl_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmd_valid_o = (state_q == ST_CMD);
  assign cmd_write_o = wr_q;
  assign cmd_addr_o  = layer_q ? pr_addr : tr_addr;
  assign cmd_len_o   = layer_q ? BW'({({1'b0, ent_q.len_m1} + 7'd1), 3'b000}) : tr_len;
  assign tbl_valid_o = (state_q == ST_TBL_RD) || (state_q == ST_TBL_WR);
  assign tbl_we_o    = (state_q == ST_TBL_WR);
  assign tbl_addr_o  = tbl_addr;
  assign tbl_wdata_o = ent_q;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int AW = 32,
  parameter int BW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic          cmd_write_o,
  input logic [AW-1:0] cmd_addr_o,
  input logic [BW-1:0] cmd_len_o,
  input logic          tbl_valid_o,
  input logic          tbl_ready_i,
  input logic          tbl_we_o,
  input logic [AW-1:0] tbl_addr_o,
  input logic          tbl_rvalid_i
);
  logic rd_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_out_q <= 1'b0;
    else if (tbl_valid_o && tbl_ready_i && !tbl_we_o) rd_out_q <= 1'b1;
    else if (tbl_rvalid_i) rd_out_q <= 1'b0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cmd_valid_o && !tbl_valid_o));

  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o) && $stable(cmd_write_o)));

  p_tbl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_valid_o && !tbl_ready_i) |=>
      (tbl_valid_o && $stable(tbl_addr_o) && $stable(tbl_we_o)));

  p_port_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && tbl_valid_o));

  p_wait_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_out_q |-> !cmd_valid_o);

  p_len_units_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o[2:0] == 3'b000 && cmd_len_o != '0));
endmodule

bind blk_addr_xlat xlat_checker #(.AW(AW), .BW(BW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_write_o  (cmd_write_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_len_o    (cmd_len_o),
  .tbl_valid_o  (tbl_valid_o),
  .tbl_ready_i  (tbl_ready_i),
  .tbl_we_o     (tbl_we_o),
  .tbl_addr_o   (tbl_addr_o),
  .tbl_rvalid_i (tbl_rvalid_i)
);

// File: tb/blk_addr_xlat_test.sv
module blk_addr_xlat_test;
  localparam int AW = 32, XW = 8, YW = 8, FRAMES = 4, LINES = 16, NW = 3, BW = 10;
  localparam int NFP = 2 * FRAMES;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [XW-1:0] cfg_bpr;
  logic [NW-1:0] cfg_trunc;
  logic [NFP*AW-1:0] tr_base, pr_base, tbl_base;
  logic req_valid, req_ready, req_write, req_layer, req_chroma;
  logic [1:0] req_frame;
  logic [XW-1:0] req_x;
  logic [YW-1:0] req_y;
  logic [BW-1:0] req_bytes;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] cmd_len;
  logic tbl_valid, tbl_ready, tbl_we, tbl_rvalid;
  logic [AW-1:0] tbl_addr;
  logic [23:0] tbl_wdata, tbl_rdata;

  blk_addr_xlat #(.AW(AW), .XW(XW), .YW(YW), .FRAMES(FRAMES), .LINES(LINES), .NW(NW), .BW(BW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_blk_per_row_i(cfg_bpr), .cfg_trunc_i(cfg_trunc),
    .cfg_tr_base_i(tr_base), .cfg_pr_base_i(pr_base), .cfg_tbl_base_i(tbl_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_layer_i(req_layer), .req_frame_i(req_frame), .req_chroma_i(req_chroma),
    .req_x_i(req_x), .req_y_i(req_y), .req_bytes_i(req_bytes),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len),
    .tbl_valid_o(tbl_valid), .tbl_ready_i(tbl_ready), .tbl_we_o(tbl_we),
    .tbl_addr_o(tbl_addr), .tbl_wdata_o(tbl_wdata),
    .tbl_rvalid_i(tbl_rvalid), .tbl_rdata_i(tbl_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_rd_addr, last_wr_addr;
  logic [23:0] last_wr_data;
  logic [23:0] tmem [logic [31:0]];
  logic [23:0] m_ent [int];
  logic [17:0] wptr_m [NFP];
  bit rd_pend = 0;
  int rd_dly = 0;
  logic [23:0] rd_data;

  function automatic logic [AW-1:0] tr_b(int fp);
    return 32'h1000_0000 + 32'(fp) * 32'h0010_0000;
  endfunction
  function automatic logic [AW-1:0] pr_b(int fp);
    return 32'h2000_0000 + 32'(fp) * 32'h0004_0000;
  endfunction
  function automatic logic [AW-1:0] tbl_b(int fp);
    return 32'h3000_0000 + 32'(fp) * 32'h0002_0000;
  endfunction
  function automatic logic [23:0] dflt(logic [31:0] a);
    return {a[19:2] ^ 18'h15a3c, a[5:0] ^ 6'h2b};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // table-region responder
  initial begin
    tbl_rvalid = 1'b0;
    tbl_rdata  = '0;
    tbl_ready  = 1'b1;
    forever begin
      @(negedge clk);
      tbl_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_dly == 0) begin
          tbl_rvalid = 1'b1;
          tbl_rdata  = rd_data;
          rd_pend    = 0;
        end else rd_dly--;
      end
      if (rst_n && tbl_valid && tbl_ready) begin
        if (tbl_we) begin
          tmem[tbl_addr] = tbl_wdata;
          last_wr_addr = tbl_addr;
          last_wr_data = tbl_wdata;
          wr_cnt++;
        end else begin
          rd_cnt++;
          last_rd_addr = tbl_addr;
          rd_data = tmem.exists(tbl_addr) ? tmem[tbl_addr] : dflt(tbl_addr);
          rd_pend = 1;
          rd_dly  = 1 + int'($urandom % 3);
        end
      end
    end
  end

  task automatic do_op(input bit wr, input bit ly, input int fr, input int ch,
                       input int x, input int y, input int nb);
    int fp, idx, key, e_len, len8, w0;
    logic [AW-1:0] e_addr, e_tbl;
    logic [23:0] e_ent;
    bit seen;
    fp  = fr * 2 + ch;
    idx = (y * int'(cfg_bpr) + x) & 32'hffff;
    key = fp * 65536 + idx;
    e_tbl = tbl_b(fp) + 32'(idx) * 3;
    e_ent = '0;
    if (!ly) begin
      e_addr = tr_b(fp) + 32'(idx) * 32'(cfg_trunc) * 8;
      e_len  = int'(cfg_trunc) * 8;
    end else if (wr) begin
      len8   = (nb + 7) / 8;
      e_ent  = {wptr_m[fp], 6'(len8 - 1)};
      e_addr = pr_b(fp) + 32'(wptr_m[fp]);
      e_len  = len8 * 8;
      wptr_m[fp] = wptr_m[fp] + 18'(len8 * 8);
      m_ent[key] = e_ent;
    end else begin
      e_ent  = m_ent.exists(key) ? m_ent[key] : dflt(e_tbl);
      e_addr = pr_b(fp) + 32'(e_ent[23:6]);
      e_len  = (int'(e_ent[5:0]) + 1) * 8;
    end
    w0 = wr_cnt;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    req_write = wr; req_layer = ly; req_frame = 2'(fr); req_chroma = ch[0];
    req_x = XW'(x); req_y = YW'(y); req_bytes = BW'(nb);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 busy", 64'(req_ready), 0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (cmd_valid) begin seen = 1; break; end
      if (req_ready) break;
      @(negedge clk);
    end
    if (!ly && cfg_trunc == 0) begin
      chk(!seen, "R3 no cmd", 64'(seen), 0);
      chk(req_ready, "R3 ready", 64'(req_ready), 1);
    end else begin
      chk(seen, "cmd missing", 64'(seen), 1);
      chk(cmd_addr == e_addr, ly ? (wr ? "R8 addr" : "R5 addr") : "R2 addr", 64'(cmd_addr), 64'(e_addr));
      chk(int'(cmd_len) == e_len, ly ? (wr ? "R8 len" : "R5 len") : "R2 len", 64'(cmd_len), 64'(e_len));
      chk(cmd_write == wr, "R2 dir", 64'(cmd_write), 64'(wr));
      repeat ($urandom % 3) @(negedge clk);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      for (int i = 0; i < 60 && !req_ready; i++) @(negedge clk);
      chk(req_ready, "R10 return", 64'(req_ready), 1);
      if (wr && ly) begin
        chk(wr_cnt == w0 + 1, "R9 tbl write count", 64'(wr_cnt - w0), 1);
        chk(last_wr_addr == e_tbl, "R9 R4 tbl addr", 64'(last_wr_addr), 64'(e_tbl));
        chk(last_wr_data == e_ent, "R9 R4 entry", 64'(last_wr_data), 64'(e_ent));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NFP; i++) begin
      tr_base[i*AW +: AW]  = tr_b(i);
      pr_base[i*AW +: AW]  = pr_b(i);
      tbl_base[i*AW +: AW] = tbl_b(i);
      wptr_m[i] = '0;
    end
    cfg_bpr = 8'd240; cfg_trunc = 3'd3;
    req_valid = 0; req_write = 0; req_layer = 0; req_frame = 0; req_chroma = 0;
    req_x = 0; req_y = 0; req_bytes = 0; cmd_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready", 64'(req_ready), 1);
    chk(!cmd_valid, "R1 cmd", 64'(cmd_valid), 0);
    chk(!tbl_valid, "R1 tbl", 64'(tbl_valid), 0);

    do_op(0, 0, 1, 1, 5, 2, 0);           // R2 read
    do_op(1, 0, 3, 0, 9, 7, 0);           // R2 write
    cfg_trunc = 3'd0;
    do_op(0, 0, 0, 0, 1, 1, 0);           // R3
    cfg_trunc = 3'd7;
    do_op(0, 0, 2, 1, 239, 3, 0);         // R2 deepest truncation

    r0 = rd_cnt;
    do_op(0, 1, 0, 0, 3, 0, 0);
    chk(rd_cnt == r0 + 1, "R6 one fetch", 64'(rd_cnt - r0), 1);
    chk(last_rd_addr == tbl_b(0) + 9, "R4 fetch addr", 64'(last_rd_addr), 64'(tbl_b(0) + 9));
    r0 = rd_cnt;
    do_op(0, 1, 0, 0, 3, 0, 0);
    chk(rd_cnt == r0, "R7 hit", 64'(rd_cnt - r0), 0);
    r0 = rd_cnt;
    do_op(0, 1, 0, 0, 19, 0, 0);
    chk(rd_cnt == r0 + 1, "R7 alias miss", 64'(rd_cnt - r0), 1);
    r0 = rd_cnt;
    do_op(0, 1, 0, 0, 3, 0, 0);
    chk(rd_cnt == r0 + 1, "R7 evicted", 64'(rd_cnt - r0), 1);
    r0 = rd_cnt;
    do_op(0, 1, 0, 1, 3, 0, 0);
    chk(rd_cnt == r0 + 1, "R7 plane differs", 64'(rd_cnt - r0), 1);

    do_op(1, 1, 2, 1, 7, 1, 1);           // R8 1 byte -> 8
    r0 = rd_cnt;
    do_op(0, 1, 2, 1, 7, 1, 0);
    chk(rd_cnt == r0, "R9 kept on chip", 64'(rd_cnt - r0), 0);
    do_op(1, 1, 2, 1, 8, 1, 512);         // R8 max size
    do_op(1, 1, 2, 1, 9, 1, 20);          // R8 rounding
    do_op(1, 1, 2, 1, 10, 1, 24);         // R8 exact multiple

    cfg_bpr = 8'd100; cfg_trunc = 3'd3;
    do_op(0, 0, 1, 1, 5, 2, 0);           // R2 new row width

    for (int k = 0; k < 400; k++) begin
      cfg_trunc = NW'($urandom % 8);
      do_op($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 2,
            $urandom % 40, $urandom % 6, 1 + ($urandom % 512));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule